// File: doc/BRIEF.md
# Masked Prioritized Interrupt Cause Unit

This block is the trap controller that sits beside a pipelined processor core. It keeps three architectural registers: a status word (per-level interrupt mask, user-mode flag, exception-level flag and global interrupt enable), a cause word (pending interrupt bits, a five-bit reason code and a branch-delay flag), and an exception PC. Six hardware interrupt lines and two software-settable bits form eight interrupt levels. Pipeline stages can raise synchronous exception requests at the same time, each carrying its own reason code, PC and branch-delay flag.

In every cycle the unit decides whether to take a trap. A synchronous exception is taken whenever the exception-level flag is clear. An interrupt is taken only if the enable bit is set, the exception-level flag is clear and some pending level is also unmasked. When a trap is taken, the unit raises a one-cycle strobe and presents a fixed handler address. It asserts flush for the fetch, decode and execute stages, and it records the reason, the faulting PC and the branch-delay flag. Software reads and writes the registers through a simple select/write-enable port with a combinational read path.

Top module: `trap_ctl`

## Requirements
- R1: After a synchronous active-low reset, the status, cause and exception PC registers all read 0 and `trap_o` is 0.
- R2: The status word places the mask at bits 15:8 (bit 8 + k enables level k), user mode at bit 4, exception level at bit 1 and interrupt enable at bit 0. All other bits read 0 and cannot be written. The select codes are 0 for status, 1 for cause and 2 for exception PC.
- R3: Cause bits 15:10 show hardware line k at bit 10 + k, one clock after the line is sampled, whatever the enable bit is. Cause bits 9:8 are the two software levels and are written only through the cause register. No other cause bit can be written by software.
- R4: An interrupt trap requires enable = 1, exception level = 0 and a non-zero (pending AND mask). Otherwise the pending bits wait without a trap.
- R5: Among the pending-and-unmasked levels, the highest bit wins. `trap_level_o` gives its level number (0 = cause bit 8, 7 = cause bit 15) while `trap_o` is high.
- R6: A synchronous exception request causes a trap whatever the enable bit is, provided exception level is 0. While exception level is 1, every request is ignored and the registers keep their values.
- R7: When several stages request in one cycle, the request at the lowest stage index wins. Index 0 is the oldest instruction.
- R8: A synchronous exception takes precedence over an interrupt that is ready in the same cycle.
- R9: In the cycle after a trap, the exception PC holds the winner's PC, cause bits 6:2 hold its code, cause bit 31 holds its branch-delay flag, and status bit 1 is 1. A trap overrides a software write to status or to the exception PC made in the same cycle.
- R10: `trap_o` is high for exactly one cycle per trap. In that cycle `trap_vec_o` equals the handler address parameter and all three flush outputs are 1; otherwise the flush outputs are 0.
- R11: An interrupt trap records code 0. The exception codes are 4 and 5 for load/fetch and store address errors, 6 and 7 for fetch and data bus errors, 8 for syscall, 9 for breakpoint, 10 for reserved instruction and 12 for overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq_i | input | 6 | Hardware interrupt request lines |
| exc_valid_i | input | NUM_STAGES | Exception request per stage, index 0 oldest |
| exc_code_i | input | 5*NUM_STAGES | Reason code per stage |
| exc_pc_i | input | 32*NUM_STAGES | Faulting instruction PC per stage |
| exc_bd_i | input | NUM_STAGES | Branch-delay flag per stage |
| irq_pc_i | input | 32 | Resume PC recorded on an interrupt trap |
| irq_bd_i | input | 1 | Branch-delay flag recorded on an interrupt trap |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 2 | Register select: 0 status, 1 cause, 2 exception PC |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the current select |
| trap_o | output | 1 | One-cycle trap strobe |
| trap_vec_o | output | 32 | Handler address |
| trap_level_o | output | 3 | Winning interrupt level |
| flush_if_o | output | 1 | Flush fetch stage |
| flush_id_o | output | 1 | Flush decode stage |
| flush_ex_o | output | 1 | Flush execute stage |

## Verification
A stuck or wrongly cleared exception-level flag shows in one of two ways. Either a second strobe appears in the cycle right after a trap, or a later exception produces no strobe at all. Both are visible within one clock. A wrong priority scan or a wrong stage pick appears at once as a wrong `trap_level_o`, and one cycle later as a wrong code or PC in the readable registers. A lost pending bit is caught through the cause read one cycle after the line changes.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the trap controller.
// Assumes a 32-bit machine word and eight interrupt levels (6 hardware, 2 software).
package trap_pkg;
    localparam int unsigned XLEN       = 32;
    localparam int unsigned CODE_W     = 5;
    localparam int unsigned NUM_HW     = 6;
    localparam int unsigned NUM_SW     = 2;
    localparam int unsigned NUM_LEVELS = NUM_HW + NUM_SW;
    localparam int unsigned LVL_W      = $clog2(NUM_LEVELS);

    // Reason codes recorded in the cause word
    typedef enum logic [CODE_W-1:0] {
        EXC_INT        = 5'd0,
        EXC_ADDR_LOAD  = 5'd4,
        EXC_ADDR_STORE = 5'd5,
        EXC_BUS_FETCH  = 5'd6,
        EXC_BUS_DATA   = 5'd7,
        EXC_SYSCALL    = 5'd8,
        EXC_BREAK      = 5'd9,
        EXC_RESVD      = 5'd10,
        EXC_OVERFLOW   = 5'd12
    } cause_code_e;

    // Register select codes of the access port
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/trap_irq_pick.sv
`timescale 1ns/1ps
// Interrupt candidate selection: pending AND mask, highest bit wins.
// Purely combinational; take_o additionally requires the gate input (enable and
// not in exception level), which the caller computes.
module trap_irq_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned LW = $clog2(N)
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  mask_i,
    input  logic          gate_i,
    output logic          take_o,
    output logic [LW-1:0] level_o
);
    logic [N-1:0] cand;

    assign cand = pend_i & mask_i;

    // Scan upward so the highest set candidate is the one left in level_o
    always_comb begin
        level_o = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i]) level_o = LW'(i);
        end
        take_o = gate_i && (cand != '0);
    end

    // The chosen level is a candidate and nothing above it is
    always_comb begin
        if (take_o) begin
            assert_level_is_top_R5: assert (cand[level_o] && ((cand >> level_o) == N'(1)))
                else $error("interrupt level is not the highest candidate");
        end
    end
endmodule

// File: rtl/trap_exc_pick.sv
`timescale 1ns/1ps
// Synchronous exception arbitration across pipeline stages.
// Assumes stage index 0 carries the oldest instruction; the lowest valid index wins.
module trap_exc_pick #(
    parameter int unsigned NS = 3,
    parameter int unsigned CW = 5,
    parameter int unsigned AW = 32,
    parameter int unsigned IW = (NS > 1) ? $clog2(NS) : 1
) (
    input  logic [NS-1:0]    valid_i,
    input  logic [NS*CW-1:0] code_i,
    input  logic [NS*AW-1:0] pc_i,
    input  logic [NS-1:0]    bd_i,
    output logic             any_o,
    output logic [CW-1:0]    code_o,
    output logic [AW-1:0]    pc_o,
    output logic             bd_o
);
    logic [IW-1:0] idx;

    // Scan from youngest to oldest so the oldest valid request is kept
    always_comb begin
        any_o  = 1'b0;
        idx    = '0;
        code_o = '0;
        pc_o   = '0;
        bd_o   = 1'b0;
        for (int s = NS - 1; s >= 0; s--) begin
            if (valid_i[s]) begin
                any_o  = 1'b1;
                idx    = IW'(s);
                code_o = code_i[s*CW +: CW];
                pc_o   = pc_i[s*AW +: AW];
                bd_o   = bd_i[s];
            end
        end
    end

    // The winner is valid and no older stage was requesting
    always_comb begin
        if (any_o) begin
            assert_oldest_wins_R7: assert (valid_i[idx] &&
                ((valid_i & ((NS'(1) << idx) - NS'(1))) == '0))
                else $error("exception winner is not the oldest request");
        end
    end
endmodule

// File: rtl/trap_ctl.sv
`timescale 1ns/1ps
// Trap controller: status, cause and exception PC registers, interrupt and
// exception arbitration, and the redirect/flush strobe.
// Assumes a synchronous active-low reset, a combinational register read path and
// a pipeline that redirects to trap_vec_o in the cycle trap_o is high.
module trap_ctl
    import trap_pkg::*;
#(
    parameter int unsigned NUM_STAGES   = 3,
    parameter logic [31:0] HANDLER_ADDR = 32'h8000_0180
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_HW-1:0]          hw_irq_i,
    input  logic [NUM_STAGES-1:0]      exc_valid_i,
    input  logic [NUM_STAGES*5-1:0]    exc_code_i,
    input  logic [NUM_STAGES*32-1:0]   exc_pc_i,
    input  logic [NUM_STAGES-1:0]      exc_bd_i,
    input  logic [31:0]                irq_pc_i,
    input  logic                       irq_bd_i,
    input  logic                       reg_we_i,
    input  logic [1:0]                 reg_sel_i,
    input  logic [31:0]                reg_wdata_i,
    output logic [31:0]                reg_rdata_o,
    output logic                       trap_o,
    output logic [31:0]                trap_vec_o,
    output logic [2:0]                 trap_level_o,
    output logic                       flush_if_o,
    output logic                       flush_id_o,
    output logic                       flush_ex_o
);
    // Architectural state
    logic [NUM_LEVELS-1:0] mask_q;
    logic                  um_q;
    logic                  exl_q;
    logic                  ie_q;
    logic [NUM_HW-1:0]     hw_pend_q;
    logic [NUM_SW-1:0]     sw_pend_q;
    logic [CODE_W-1:0]     code_q;
    logic                  bd_q;
    logic [XLEN-1:0]       epc_q;

    // Arbitration results
    logic                  exc_any;
    logic [CODE_W-1:0]     exc_code;
    logic [XLEN-1:0]       exc_pc;
    logic                  exc_bd;
    logic                  irq_take;
    logic [LVL_W-1:0]      irq_level;
    logic                  exc_take;
    logic                  take;
    logic [CODE_W-1:0]     sel_code;
    logic [XLEN-1:0]       sel_pc;
    logic                  sel_bd;
    logic                  wr_status;
    logic                  wr_cause;
    logic                  wr_epc;

    trap_irq_pick #(
        .N  (NUM_LEVELS),
        .LW (LVL_W)
    ) i_irq_pick (
        .pend_i  ({hw_pend_q, sw_pend_q}),
        .mask_i  (mask_q),
        .gate_i  (ie_q && !exl_q),
        .take_o  (irq_take),
        .level_o (irq_level)
    );

    trap_exc_pick #(
        .NS (NUM_STAGES),
        .CW (CODE_W),
        .AW (XLEN)
    ) i_exc_pick (
        .valid_i (exc_valid_i),
        .code_i  (exc_code_i),
        .pc_i    (exc_pc_i),
        .bd_i    (exc_bd_i),
        .any_o   (exc_any),
        .code_o  (exc_code),
        .pc_o    (exc_pc),
        .bd_o    (exc_bd)
    );

    // Trap decision: exceptions ignore enable, both are blocked by exception level
    always_comb begin
        exc_take = exc_any && !exl_q;
        take     = exc_take || irq_take;
        sel_code = exc_take ? exc_code : EXC_INT;
        sel_pc   = exc_take ? exc_pc   : irq_pc_i;
        sel_bd   = exc_take ? exc_bd   : irq_bd_i;
    end

    // Software write decode
    always_comb begin
        wr_status = reg_we_i && (reg_sel_i == SEL_STATUS);
        wr_cause  = reg_we_i && (reg_sel_i == SEL_CAUSE);
        wr_epc    = reg_we_i && (reg_sel_i == SEL_EPC);
    end

    // Status register: a trap sets exception level and overrides software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            um_q   <= 1'b0;
            exl_q  <= 1'b0;
            ie_q   <= 1'b0;
        end else if (take) begin
            exl_q  <= 1'b1;
        end else if (wr_status) begin
            mask_q <= reg_wdata_i[15:8];
            um_q   <= reg_wdata_i[4];
            exl_q  <= reg_wdata_i[1];
            ie_q   <= reg_wdata_i[0];
        end
    end

    // Hardware pending bits follow the lines each cycle, whatever the enable
    always_ff @(posedge clk) begin
        if (!rst_n) hw_pend_q <= '0;
        else        hw_pend_q <= hw_irq_i;
    end

    // Software pending bits are written through the cause register only
    always_ff @(posedge clk) begin
        if (!rst_n)        sw_pend_q <= '0;
        else if (wr_cause) sw_pend_q <= reg_wdata_i[9:8];
    end

    // Cause code and branch-delay flag are recorded on a trap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            bd_q   <= 1'b0;
        end else if (take) begin
            code_q <= sel_code;
            bd_q   <= sel_bd;
        end
    end

    // Exception PC: trap capture wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n)      epc_q <= '0;
        else if (take)   epc_q <= sel_pc;
        else if (wr_epc) epc_q <= reg_wdata_i;
    end

    // Register read mux
    always_comb begin
        unique case (reg_sel_i)
            SEL_STATUS: reg_rdata_o = {16'b0, mask_q, 3'b0, um_q, 2'b0, exl_q, ie_q};
            SEL_CAUSE:  reg_rdata_o = {bd_q, 15'b0, hw_pend_q, sw_pend_q, 1'b0, code_q, 2'b0};
            SEL_EPC:    reg_rdata_o = epc_q;
            default:    reg_rdata_o = '0;
        endcase
    end

    // Redirect and flush outputs
    always_comb begin
        trap_o       = take;
        trap_vec_o   = HANDLER_ADDR;
        trap_level_o = irq_level;
        flush_if_o   = take;
        flush_id_o   = take;
        flush_ex_o   = take;
    end

    // A trap leaves the unit in exception level
    assert_exl_after_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> exl_q);

    // The recorded PC is the one that was selected in the trap cycle
    assert_epc_captured_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> (epc_q == $past(sel_pc)));

    // The strobe never lasts two cycles
    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);

    // Without any exception request, a trap needs the enable bit
    assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && (exc_valid_i == '0)) |-> ie_q);

    // Exception level blocks every trap
    assert_blocked_in_exl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exl_q |-> !trap_o);

    // Hardware pending bits track the lines with one cycle delay
    assert_pending_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hw_pend_q == $past(hw_irq_i)));
endmodule

// File: tb/test_trap_ctl.sv
`timescale 1ns/1ps
// Directed bench for trap_ctl: one task per scenario, each checking its own results.
module test_trap_ctl;
    localparam int unsigned NS      = 3;
    localparam logic [31:0] HANDLER = 32'h8000_0180;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [5:0]    hw_irq;
    logic [NS-1:0] exc_valid;
    logic [NS*5-1:0]  exc_code;
    logic [NS*32-1:0] exc_pc;
    logic [NS-1:0] exc_bd;
    logic [31:0]   irq_pc;
    logic          irq_bd;
    logic          reg_we;
    logic [1:0]    reg_sel;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          trap;
    logic [31:0]   trap_vec;
    logic [2:0]    trap_level;
    logic          fl_if, fl_id, fl_ex;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    trap_ctl #(.NUM_STAGES(NS), .HANDLER_ADDR(HANDLER)) i_trap_ctl (
        .clk(clk), .rst_n(rst_n), .hw_irq_i(hw_irq),
        .exc_valid_i(exc_valid), .exc_code_i(exc_code), .exc_pc_i(exc_pc), .exc_bd_i(exc_bd),
        .irq_pc_i(irq_pc), .irq_bd_i(irq_bd),
        .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .trap_o(trap), .trap_vec_o(trap_vec), .trap_level_o(trap_level),
        .flush_if_o(fl_if), .flush_id_o(fl_id), .flush_ex_o(fl_ex)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    // Write at a falling edge; returns at the next falling edge, register updated
    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_exc(input int s, input logic [4:0] code, input logic [31:0] pc, input logic bd);
        exc_valid[s] = 1'b1;
        exc_code[s*5 +: 5] = code;
        exc_pc[s*32 +: 32] = pc;
        exc_bd[s] = bd;
    endtask

    task automatic check_trap_cycle(input string req, input logic [2:0] lvl, input bit lvl_chk);
        #1;
        chk(req, "trap strobe", {31'b0, trap}, 32'd1);
        chk("R10", "handler address", trap_vec, HANDLER);
        chk("R10", "flush if/id/ex", {29'b0, fl_if, fl_id, fl_ex}, 32'd7);
        if (lvl_chk) chk("R5", "interrupt level", {29'b0, trap_level}, {29'b0, lvl});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v); chk("R1", "status after reset", v, 32'h0);
        rd(2'd1, v); chk("R1", "cause after reset", v, 32'h0);
        rd(2'd2, v); chk("R1", "epc after reset", v, 32'h0);
        chk("R1", "no trap after reset", {31'b0, trap}, 32'd0);
    endtask

    task automatic t_status_fields;
        logic [31:0] v;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R2", "status writable bits", v, 32'h0000_FF13);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R2", "status cleared", v, 32'h0);
    endtask

    task automatic t_pending_disabled;
        logic [31:0] v;
        @(negedge clk); hw_irq = 6'b100101;
        @(negedge clk);
        rd(2'd1, v); chk("R3", "hw pending while disabled", v, 32'h0000_9400);
        chk("R4", "no trap while disabled", {31'b0, trap}, 32'd0);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R3", "only sw pending writable", v, 32'h0000_9700);
        wr(2'd0, 32'h0000_0001);   // enabled, all masked
        #1; chk("R4", "no trap when all masked", {31'b0, trap}, 32'd0);
        @(negedge clk);
        chk("R4", "still no trap when masked", {31'b0, trap}, 32'd0);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        irq_pc = 32'h0000_3006; irq_bd = 1'b0;
        wr(2'd0, 32'h0000_3F01);   // levels 0..5 unmasked; candidates 0,1,2,4
        check_trap_cycle("R4", 3'd4, 1'b1);
        @(negedge clk);
        chk("R10", "strobe one cycle", {31'b0, trap}, 32'd0);
        rd(2'd0, v); chk("R9", "exception level set", v, 32'h0000_3F03);
        rd(2'd1, v); chk("R11", "interrupt code 0", v, 32'h0000_9700);
        rd(2'd2, v); chk("R9", "epc from interrupt", v, 32'h0000_3006);
        irq_pc = 32'h0000_4000;
        wr(2'd0, 32'h0000_0101);   // only level 0 unmasked, exl cleared
        check_trap_cycle("R5", 3'd0, 1'b1);
        @(negedge clk);
        rd(2'd2, v); chk("R9", "epc second interrupt", v, 32'h0000_4000);
        hw_irq = 6'b0;
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_exc_disabled;
        logic [31:0] v;
        @(negedge clk); set_exc(1, 5'd12, 32'h0000_0100, 1'b1);
        check_trap_cycle("R6", 3'd0, 1'b0);
        @(negedge clk); exc_valid = '0;
        rd(2'd2, v); chk("R9", "epc from exception", v, 32'h0000_0100);
        rd(2'd1, v); chk("R9", "cause code and bd", v, 32'h8000_0030);
        rd(2'd0, v); chk("R9", "exl after exception", v, 32'h0000_0002);
        // Blocked while exception level is set
        @(negedge clk); set_exc(0, 5'd8, 32'h0000_0200, 1'b0);
        #1; chk("R6", "ignored in exception level", {31'b0, trap}, 32'd0);
        @(negedge clk); exc_valid = '0;
        rd(2'd2, v); chk("R6", "epc kept while blocked", v, 32'h0000_0100);
        rd(2'd1, v); chk("R6", "cause kept while blocked", v, 32'h8000_0030);
        wr(2'd0, 32'h0);
    endtask

    task automatic t_oldest;
        logic [31:0] v;
        @(negedge clk);
        set_exc(0, 5'd4,  32'h0000_0300, 1'b0);
        set_exc(1, 5'd10, 32'h0000_0304, 1'b0);
        set_exc(2, 5'd9,  32'h0000_0308, 1'b1);
        check_trap_cycle("R7", 3'd0, 1'b0);
        @(negedge clk); exc_valid = '0;
        rd(2'd2, v); chk("R7", "stage 0 pc", v, 32'h0000_0300);
        rd(2'd1, v); chk("R7", "stage 0 code", v, 32'h0000_0010);
        wr(2'd0, 32'h0);
        @(negedge clk);
        set_exc(1, 5'd10, 32'h0000_0304, 1'b0);
        set_exc(2, 5'd9,  32'h0000_0308, 1'b1);
        check_trap_cycle("R7", 3'd0, 1'b0);
        @(negedge clk); exc_valid = '0;
        rd(2'd2, v); chk("R7", "stage 1 pc", v, 32'h0000_0304);
        rd(2'd1, v); chk("R7", "stage 1 code", v, 32'h0000_0028);
    endtask

    task automatic t_exc_over_irq;
        logic [31:0] v;
        // exception level is still set here, so the request below waits
        @(negedge clk);
        hw_irq = 6'b000001;
        irq_pc = 32'h0000_5000;
        set_exc(2, 5'd7, 32'h0000_0400, 1'b0);
        wr(2'd0, 32'h0000_FF01);   // interrupt and exception both ready now
        check_trap_cycle("R8", 3'd0, 1'b0);
        @(negedge clk); exc_valid = '0; hw_irq = 6'b0;
        rd(2'd2, v); chk("R8", "exception pc wins", v, 32'h0000_0400);
        rd(2'd1, v); chk("R8", "exception code wins", v, 32'h0000_041C);
    endtask

    initial begin
        rst_n = 1'b0; hw_irq = '0; exc_valid = '0; exc_code = '0; exc_pc = '0; exc_bd = '0;
        irq_pc = '0; irq_bd = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status_fields();
        t_pending_disabled();
        t_priority();
        t_exc_disabled();
        t_oldest();
        t_exc_over_irq();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule